// File: doc/BRIEF.md
# Character-Serial Memory OR Engine

This block is a sequencer that ORs two equal-length strings of characters held in a character-addressed store. It writes the result over the first string. A single start pulse loads a first-string address, a second-string address and a character count. Each address points at the least significant, rightmost character of its string. The engine then works leftward one character at a time. For each character it reads the second string, reads the first string, and writes back the OR of their six information bits with a newly generated odd-parity bit.

When it finishes, the engine raises a one-cycle done pulse. At that point its registers show where each string ended, and a time counter shows the cost of the operation under a fixed-setup, fixed-per-character cost model. The memory port is single-ported and synchronous. It allows one access per cycle and returns read data one cycle after the request.

Top module: `or_string_engine`

## Requirements
- R1: A count of zero raises done with no memory access. The address outputs still equal the loaded addresses, and the time counter reads SETUP_COST (35).
- R2: Bits [5:0] of each written character equal the bitwise OR of bits [5:0] of the first-string and second-string characters at the same offset.
- R3: Bit 6 of each written character makes the seven bits hold an odd number of ones. Bit 6 of both input characters has no effect on the result.
- R4: Character k, counted from 0, is read from address a-k and b-k and written to address a-k. No other location changes, and the second string is left intact.
- R5: At completion the first address output equals a-n, the second address output equals b-n, and the count output is 0.
- R6: At completion the time counter equals CHAR_COST*n + SETUP_COST (21n + 35).
- R7: Each character uses exactly three accesses in this order: a read at b-k, a read at a-k, then a write at a-k. An operation therefore makes 3n accesses.
- R8: Take the edge that samples start as edge 0. done_o is high for exactly one cycle, starting after edge 4n+1. busy_o is high from edge 0 until done ends.
- R9: A start request while busy_o is high is ignored. The operation in progress and its results do not change.
- R10: A requested count above MAX_COUNT (44) is treated as MAX_COUNT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled only when idle |
| a_addr_i | input | AW | Address of the rightmost character of the first string and result |
| b_addr_i | input | AW | Address of the rightmost character of the second string |
| count_i | input | CW | Requested character count |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| a_addr_o | output | AW | Current first-string address register |
| b_addr_o | output | AW | Current second-string address register |
| count_o | output | CW | Remaining character count |
| cycles_o | output | TW | Accumulated time units |
| mem_en_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | 7 | Memory write data, parity in bit 6 |
| mem_rdata_i | input | 7 | Memory read data, valid one cycle after a read request |

## Verification
With start sampled at edge 0, the bench expects done after edge 4n+1. It counts negedges from the edge that sampled start and compares that count exactly. It reads the address, count and time-counter outputs during the done cycle, then confirms one negedge later that done has fallen. Memory results are compared only after done, once all 3n accesses have landed. Each access is logged at the edge where the request is sampled, so its order and addresses can be checked against b-k, a-k, a-k.

// File: rtl/or_eng_pkg.sv
package or_eng_pkg;
  localparam int unsigned CHAR_W = 7;
  localparam int unsigned INFO_W = 6;

  typedef logic [CHAR_W-1:0] char_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_RD_B  = 3'd2,
    ST_RD_A  = 3'd3,
    ST_WR    = 3'd4,
    ST_DONE  = 3'd5
  } state_e;

  function automatic char_t odd_char(input logic [INFO_W-1:0] info);
    return {~^info, info};
  endfunction
endpackage

// File: rtl/or_eng_merge.sv
module or_eng_merge
  import or_eng_pkg::*;
(
  input  char_t a_char_i,
  input  char_t b_char_i,
  output char_t res_o
);
  logic [INFO_W-1:0] info;

  assign info  = a_char_i[INFO_W-1:0] | b_char_i[INFO_W-1:0];
  assign res_o = odd_char(info);

  always_comb begin
    assert_odd_parity_R3: assert (^res_o == 1'b1)
      else $error("result parity not odd");
  end
endmodule

// File: rtl/or_eng_ctrl.sv
module or_eng_ctrl
  import or_eng_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   cnt_zero_i,
  output state_e state_o,
  output logic   load_o,
  output logic   step_o,
  output logic   capture_b_o,
  output logic   sel_a_o,
  output logic   mem_en_o,
  output logic   mem_we_o,
  output logic   busy_o,
  output logic   done_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_CHECK;
      ST_CHECK: state_d = cnt_zero_i ? ST_DONE : ST_RD_B;
      ST_RD_B:  state_d = ST_RD_A;
      ST_RD_A:  state_d = ST_WR;
      ST_WR:    state_d = ST_CHECK;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign load_o      = (state_q == ST_IDLE) && start_i;
  assign step_o      = (state_q == ST_WR);
  // read data for B lands while A is being requested
  assign capture_b_o = (state_q == ST_RD_A);
  assign sel_a_o     = (state_q == ST_RD_A) || (state_q == ST_WR);
  assign mem_en_o    = (state_q == ST_RD_B) || sel_a_o;
  assign mem_we_o    = (state_q == ST_WR);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_zero_exit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHECK && cnt_zero_i) |=> (done_o && !mem_en_o));

  assert_read_then_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_B) |=> (mem_en_o && !mem_we_o) ##1 mem_we_o);

  assert_idle_only_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && state_q != ST_WR) |=> busy_o);
endmodule

// File: rtl/or_eng_regs.sv
module or_eng_regs #(
  parameter int AW         = 10,
  parameter int CW         = 6,
  parameter int TW         = 10,
  parameter int MAX_COUNT  = 44,
  parameter int SETUP_COST = 35,
  parameter int CHAR_COST  = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] b_i,
  input  logic [CW-1:0] cnt_i,
  output logic [AW-1:0] a_o,
  output logic [AW-1:0] b_o,
  output logic [CW-1:0] cnt_o,
  output logic [TW-1:0] cyc_o,
  output logic          cnt_zero_o
);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_COUNT);
  localparam logic [TW-1:0] T_SETUP = TW'(SETUP_COST);
  localparam logic [TW-1:0] T_CHAR  = TW'(CHAR_COST);

  logic [AW-1:0] a_q, b_q;
  logic [CW-1:0] cnt_q, cnt_ld;
  logic [TW-1:0] cyc_q;

  assign cnt_ld = (cnt_i > CNT_MAX) ? CNT_MAX : cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      cnt_q <= '0;
      cyc_q <= '0;
    end else if (load_i) begin
      a_q   <= a_i;
      b_q   <= b_i;
      cnt_q <= cnt_ld;
      cyc_q <= T_SETUP;
    end else if (step_i) begin
      a_q   <= a_q - 1'b1;
      b_q   <= b_q - 1'b1;
      cnt_q <= cnt_q - 1'b1;
      cyc_q <= cyc_q + T_CHAR;
    end
  end

  assign a_o        = a_q;
  assign b_o        = b_q;
  assign cnt_o      = cnt_q;
  assign cyc_o      = cyc_q;
  assign cnt_zero_o = (cnt_q == '0);

  assert_step_dec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (a_q == AW'($past(a_q) - 1'b1)) && (b_q == AW'($past(b_q) - 1'b1))
               && (cnt_q == CW'($past(cnt_q) - 1'b1)));

  assert_cost_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> cyc_q == TW'($past(cyc_q) + T_CHAR));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> ($stable(a_q) && $stable(b_q) && $stable(cnt_q) && $stable(cyc_q)));

  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
endmodule

// File: rtl/or_string_engine.sv
module or_string_engine
  import or_eng_pkg::*;
#(
  parameter int AW         = 10,
  parameter int MAX_COUNT  = 44,
  parameter int SETUP_COST = 35,
  parameter int CHAR_COST  = 21,
  localparam int CW        = $clog2(MAX_COUNT + 1),
  localparam int TW        = $clog2(CHAR_COST * MAX_COUNT + SETUP_COST + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [CW-1:0] count_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] a_addr_o,
  output logic [AW-1:0] b_addr_o,
  output logic [CW-1:0] count_o,
  output logic [TW-1:0] cycles_o,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [6:0]    mem_wdata_o,
  input  logic [6:0]    mem_rdata_i
);
  state_e state;
  logic   load, step, capture_b, sel_a, cnt_zero;
  char_t  b_hold_q, res;

  or_eng_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .cnt_zero_i  (cnt_zero),
    .state_o     (state),
    .load_o      (load),
    .step_o      (step),
    .capture_b_o (capture_b),
    .sel_a_o     (sel_a),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  or_eng_regs #(
    .AW(AW), .CW(CW), .TW(TW), .MAX_COUNT(MAX_COUNT),
    .SETUP_COST(SETUP_COST), .CHAR_COST(CHAR_COST)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .step_i     (step),
    .a_i        (a_addr_i),
    .b_i        (b_addr_i),
    .cnt_i      (count_i),
    .a_o        (a_addr_o),
    .b_o        (b_addr_o),
    .cnt_o      (count_o),
    .cyc_o      (cycles_o),
    .cnt_zero_o (cnt_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        b_hold_q <= '0;
    else if (capture_b) b_hold_q <= mem_rdata_i;
  end

  or_eng_merge u_merge (
    .a_char_i (mem_rdata_i),
    .b_char_i (b_hold_q),
    .res_o    (res)
  );

  assign mem_addr_o  = sel_a ? a_addr_o : b_addr_o;
  assign mem_wdata_o = res;

  assert_no_zero_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !cnt_zero);

  assert_write_steps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (state == ST_CHECK) && !mem_en_o);

  assert_done_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> count_o == '0);
endmodule

// File: tb/tb_or_string_engine.sv
module tb_or_string_engine;
  localparam int AW = 10;
  localparam int MEMSZ = 1 << AW;
  localparam int MAXC = 44;
  localparam int CW = $clog2(MAXC + 1);
  localparam int TW = $clog2(21 * MAXC + 35 + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [AW-1:0] a_addr_i = '0, b_addr_i = '0;
  logic [CW-1:0] count_i = '0;
  logic busy_o, done_o, mem_en_o, mem_we_o;
  logic [AW-1:0] a_addr_o, b_addr_o, mem_addr_o;
  logic [CW-1:0] count_o;
  logic [TW-1:0] cycles_o;
  logic [6:0] mem_wdata_o, mem_rdata_i;

  int n_chk = 0, n_fail = 0;
  logic [6:0] mem [MEMSZ];
  logic [6:0] expm [MEMSZ];
  int acc_total = 0;
  logic [AW-1:0] log_addr [256];
  logic log_we [256];

  always #10 clk = ~clk;

  or_string_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i),
    .a_addr_i(a_addr_i), .b_addr_i(b_addr_i), .count_i(count_i),
    .busy_o(busy_o), .done_o(done_o), .a_addr_o(a_addr_o), .b_addr_o(b_addr_o),
    .count_o(count_o), .cycles_o(cycles_o), .mem_en_o(mem_en_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  always @(posedge clk) begin
    if (mem_en_o) begin
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      else          mem_rdata_i <= mem[mem_addr_o];
      log_addr[acc_total % 256] <= mem_addr_o;
      log_we[acc_total % 256]   <= mem_we_o;
      acc_total <= acc_total + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] odd7(input logic [5:0] d);
    return {~^d, d};
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < MEMSZ; i++) mem[i] = 7'((i * 37 + seed * 11) ^ (i >> 3));
  endtask

  task automatic run_op(input int a, input int b, input int nreq, input bit poke);
    int n, k, base, ai, bi, cnt_bad;
    n = (nreq > MAXC) ? MAXC : nreq;
    for (int i = 0; i < MEMSZ; i++) expm[i] = mem[i];
    for (int j = 0; j < n; j++) begin
      ai = (a - j) & (MEMSZ - 1);
      bi = (b - j) & (MEMSZ - 1);
      expm[ai] = odd7(mem[ai][5:0] | mem[bi][5:0]);
    end
    @(negedge clk);
    base = acc_total;
    a_addr_i = AW'(a); b_addr_i = AW'(b); count_i = CW'(nreq); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R8", "busy after start", int'(busy_o), 1);
    k = 0;
    while (!done_o && k < 400) begin
      if (poke && k == 3) begin
        start_i = 1'b1; a_addr_i = AW'(a - 200); b_addr_i = AW'(b - 200); count_i = CW'(1);
      end
      if (poke && k == 4) start_i = 1'b0;
      @(negedge clk);
      k++;
    end
    chk(k == 4 * n + 1, poke ? "R9" : "R8", "done latency", k, 4 * n + 1);
    chk(a_addr_o == AW'(a - n), "R5", "final a", int'(a_addr_o), (a - n) & (MEMSZ - 1));
    chk(b_addr_o == AW'(b - n), "R5", "final b", int'(b_addr_o), (b - n) & (MEMSZ - 1));
    chk(count_o == '0, "R5", "final count", int'(count_o), 0);
    chk(int'(cycles_o) == 21 * n + 35, n == 0 ? "R1" : "R6", "cycles", int'(cycles_o), 21 * n + 35);
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R8", "done one cycle", int'(done_o), 0);
    chk(acc_total - base == 3 * n, n == 0 ? "R1" : "R7", "access count", acc_total - base, 3 * n);
    cnt_bad = 0;
    for (int j = 0; j < n; j++) begin
      if (log_addr[(base + 3*j) % 256]   != AW'(b - j) || log_we[(base + 3*j) % 256]   != 1'b0) cnt_bad++;
      if (log_addr[(base + 3*j+1) % 256] != AW'(a - j) || log_we[(base + 3*j+1) % 256] != 1'b0) cnt_bad++;
      if (log_addr[(base + 3*j+2) % 256] != AW'(a - j) || log_we[(base + 3*j+2) % 256] != 1'b1) cnt_bad++;
    end
    chk(cnt_bad == 0, "R7", "access order", cnt_bad, 0);
    for (int j = 0; j < n; j++) begin
      ai = (a - j) & (MEMSZ - 1);
      chk(mem[ai] == expm[ai], "R2", "result char", int'(mem[ai]), int'(expm[ai]));
    end
    cnt_bad = 0;
    for (int i = 0; i < MEMSZ; i++) if (mem[i] !== expm[i]) cnt_bad++;
    chk(cnt_bad == 0, "R4", "untouched locations", cnt_bad, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    fill(1);
    repeat (3) @(negedge clk);
    chk(done_o == 0 && busy_o == 0 && mem_en_o == 0, "R8", "reset idle", int'(busy_o), 0);
    chk(cycles_o == '0 && count_o == '0, "R5", "reset regs", int'(cycles_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // zero count
    run_op(300, 700, 0, 0);

    // worked pairs, parity bits of inputs as given
    fill(2);
    mem[101] = 7'b1001001; mem[601] = 7'b1010001;
    mem[100] = 7'b0110001; mem[600] = 7'b0100011;
    run_op(101, 601, 2, 0);
    chk(mem[101] == 7'b0011001, "R3", "example one", int'(mem[101]), 7'b0011001);
    chk(mem[100] == 7'b1110011, "R3", "example two", int'(mem[100]), 7'b1110011);

    // exhaustive 6-bit pairs, input parity bits varied to show they are ignored
    for (int j = 0; j < 94; j++) begin
      for (int i = 0; i < MAXC; i++) begin
        int p;
        p = (j * MAXC + i) % 4096;
        mem[500 - i] = {1'((p * 7) >> 2), 6'(p >> 6)};
        mem[900 - i] = {1'((p * 13) >> 3), 6'(p)};
      end
      run_op(500, 900, MAXC, 0);
      for (int i = 0; i < MAXC; i++) begin
        int p;
        p = (j * MAXC + i) % 4096;
        chk(mem[500 - i] == odd7(6'(p >> 6) | 6'(p)), "R3", "parity/or sweep",
            int'(mem[500 - i]), int'(odd7(6'(p >> 6) | 6'(p))));
      end
    end

    // length sweep, including wrap through address 0
    for (int n = 0; n <= MAXC; n++) begin
      fill(n + 5);
      run_op(250 + n, 800 - n, n, 0);
    end
    fill(77);
    run_op(10, 600, 30, 0);

    // clamp above maximum
    fill(9);
    run_op(400, 200, 60, 0);

    // start while busy
    fill(11);
    run_op(450, 950, 12, 1);
    fill(12);
    run_op(450, 950, 1, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule